// File: doc/BRIEF.md
# Segment Address Translation Unit

This block turns a segmented logical address into a physical address. A request carries a segment number and a displacement. The segment number is added to a base register, and the sum wraps modulo the table size. That sum selects one entry of an internal segment table. Each entry holds a present flag, an access-rights code, a segment length and a physical start address. The physical address is the start address plus the displacement. An adder forms this sum. It is not a concatenation of fields.

Each request is checked for three faults. The segment may be absent. The displacement may run past the segment length. The kind of access may not be allowed by the segment's rights. Only the fault with the highest priority is reported. A host-side write port loads table entries and the base register. The response is registered and appears exactly one cycle after the request.

Top module: `seg_xlate`

## Requirements
- R1: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low in every other cycle.
- R2: The table index is `(req_seg + base) mod 2^SEG_W`. The base is loaded through `cfg_base_we`/`cfg_base`.
- R3: On a fault-free response, `rsp_pa` equals the entry's start address plus the zero-extended displacement, truncated to PA_W bits.
- R4: If the selected entry is not present, `rsp_fault` = 2'd1 (missing segment).
- R5: If the displacement is strictly greater than the entry length, `rsp_fault` = 2'd2 (overflow). A displacement equal to the length is legal.
- R6: `rsp_fault` = 2'd3 (protection) when the access kind does not fit the rights code. Kind codes are 0 read, 1 write, 2 execute, 3 reserved. Rights codes are 0 read-only (allows read), 1 read/write (allows read and write), 2 execute-only (allows execute), 3 no access. Kind 3 is never allowed.
- R7: Priority is missing, then overflow, then protection. Only one code is reported.
- R8: On any faulting response, `rsp_pa` is zero.
- R9: After reset, `rsp_valid` is low, the base is 0 and every entry is not present.
- R10: A request uses the table and base contents from before any write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base_we | input | 1 | Load the base register |
| cfg_base | input | SEG_W | New base value |
| tbl_we | input | 1 | Write one table entry |
| tbl_idx | input | SEG_W | Entry to write |
| tbl_present | input | 1 | Present flag to store |
| tbl_rights | input | 2 | Rights code to store |
| tbl_len | input | LEN_W | Segment length to store |
| tbl_start | input | PA_W | Physical start address to store |
| req_valid | input | 1 | Translation request |
| req_seg | input | SEG_W | Segment number |
| req_disp | input | DISP_W | Displacement |
| req_kind | input | 2 | Access kind |
| rsp_valid | output | 1 | Response valid |
| rsp_pa | output | PA_W | Physical address |
| rsp_fault | output | 2 | Fault code, 0 = none |

## Verification
The bench targets the following corner cases:

- **Length boundary.** It probes a displacement equal to the length and one above it. A design that used `>=` would fault on a legal access.
- **Priority.** It stacks faults: an absent segment with an oversize displacement and a bad kind, then a present one with overflow and a bad kind. A design with the priority order wrong would report overflow or protection instead of missing.
- **Base wrap and address wrap.** It moves the base so that the index wraps past the top of the table. It also places a start address near the top of the physical space. A design that dropped the wrap would read the wrong entry or produce a wider or saturated address.
- **Same-cycle write.** It writes the entry being looked up in the same cycle. A design that forwarded the new contents would answer with the new entry instead of the old one.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_W  = 4,
  parameter int DISP_W = 16,
  parameter int LEN_W  = 16,
  parameter int PA_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_base_we,
  input  logic [SEG_W-1:0]  cfg_base,
  input  logic              tbl_we,
  input  logic [SEG_W-1:0]  tbl_idx,
  input  logic              tbl_present,
  input  logic [1:0]        tbl_rights,
  input  logic [LEN_W-1:0]  tbl_len,
  input  logic [PA_W-1:0]   tbl_start,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [1:0]        req_kind,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [1:0]        rsp_fault
);
  localparam int NSEG  = 1 << SEG_W;
  localparam int CMP_W = (DISP_W > LEN_W) ? DISP_W : LEN_W;

  logic [NSEG-1:0]  present_q;
  logic [1:0]       rights_q [NSEG];
  logic [LEN_W-1:0] len_q    [NSEG];
  logic [PA_W-1:0]  start_q  [NSEG];
  logic [SEG_W-1:0] base_q;

  logic [SEG_W-1:0] idx;
  logic             hit_present;
  logic [1:0]       hit_rights;
  logic             ovf;
  logic             allowed;
  logic [PA_W-1:0]  sum;
  logic [1:0]       fault_d;

  assign idx         = req_seg + base_q;
  assign hit_present = present_q[idx];
  assign hit_rights  = rights_q[idx];
  assign ovf         = CMP_W'(req_disp) > CMP_W'(len_q[idx]);
  assign sum         = start_q[idx] + PA_W'(req_disp);

  always_comb begin
    case (hit_rights)
      2'd0:    allowed = (req_kind == 2'd0);
      2'd1:    allowed = (req_kind == 2'd0) || (req_kind == 2'd1);
      2'd2:    allowed = (req_kind == 2'd2);
      default: allowed = 1'b0;
    endcase
  end

  always_comb begin
    if (!hit_present)  fault_d = 2'd1;
    else if (ovf)      fault_d = 2'd2;
    else if (!allowed) fault_d = 2'd3;
    else               fault_d = 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present_q <= '0;
      base_q    <= '0;
      for (int i = 0; i < NSEG; i++) begin
        rights_q[i] <= '0;
        len_q[i]    <= '0;
        start_q[i]  <= '0;
      end
    end else begin
      if (cfg_base_we) base_q <= cfg_base;
      if (tbl_we) begin
        present_q[tbl_idx] <= tbl_present;
        rights_q[tbl_idx]  <= tbl_rights;
        len_q[tbl_idx]     <= tbl_len;
        start_q[tbl_idx]   <= tbl_start;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_fault <= 2'd0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid ? fault_d : 2'd0;
      rsp_pa    <= (req_valid && fault_d == 2'd0) ? sum : '0;
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r4_missing: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !present_q[idx] |=> rsp_fault == 2'd1);
  a_r5_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && present_q[idx] && ovf |=> rsp_fault == 2'd2);
  a_r3_sum: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && present_q[idx] && !ovf && allowed
      |=> rsp_fault == 2'd0 && rsp_pa == $past(start_q[idx] + PA_W'(req_disp)));
  a_r8_fault_pa_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != 2'd0 |-> rsp_pa == '0);
endmodule

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
  localparam int SEG_W = 4, DISP_W = 16, LEN_W = 16, PA_W = 24;
  localparam int NSEG = 1 << SEG_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_base_we = 0;
  logic [SEG_W-1:0] cfg_base = 0;
  logic tbl_we = 0;
  logic [SEG_W-1:0] tbl_idx = 0;
  logic tbl_present = 0;
  logic [1:0] tbl_rights = 0;
  logic [LEN_W-1:0] tbl_len = 0;
  logic [PA_W-1:0] tbl_start = 0;
  logic req_valid = 0;
  logic [SEG_W-1:0] req_seg = 0;
  logic [DISP_W-1:0] req_disp = 0;
  logic [1:0] req_kind = 0;
  logic rsp_valid;
  logic [PA_W-1:0] rsp_pa;
  logic [1:0] rsp_fault;

  always #4 clk = ~clk;

  seg_xlate #(.SEG_W(SEG_W), .DISP_W(DISP_W), .LEN_W(LEN_W), .PA_W(PA_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_base_we(cfg_base_we), .cfg_base(cfg_base),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_present(tbl_present),
    .tbl_rights(tbl_rights), .tbl_len(tbl_len), .tbl_start(tbl_start),
    .req_valid(req_valid), .req_seg(req_seg), .req_disp(req_disp),
    .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
    .rsp_fault(rsp_fault));

  int checks = 0, failures = 0, cycles = 0;

  bit m_pres [NSEG];
  int m_rights [NSEG];
  longint m_len [NSEG];
  longint m_start [NSEG];
  int m_base = 0;

  function automatic bit kind_ok(int rights, int kind);
    if (rights == 0) return kind == 0;
    if (rights == 1) return kind == 0 || kind == 1;
    if (rights == 2) return kind == 2;
    return 0;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit e_valid;
    int e_fault;
    longint e_pa;
    string tag;
    e_valid = 0; e_fault = 0; e_pa = 0; tag = "R1";
    cycles++;
    if (!rst_n) begin
      tag = "R9";
      m_base = 0;
      for (int i = 0; i < NSEG; i++) begin
        m_pres[i] = 0; m_rights[i] = 0; m_len[i] = 0; m_start[i] = 0;
      end
    end else begin
      if (req_valid) begin
        int ix;
        bit ov;
        ix = (int'(req_seg) + m_base) % NSEG;
        ov = longint'(req_disp) > m_len[ix];
        e_valid = 1;
        if (!m_pres[ix]) begin e_fault = 1; tag = ov ? "R7" : "R4"; end
        else if (ov) begin e_fault = 2; tag = kind_ok(m_rights[ix], req_kind) ? "R5" : "R7"; end
        else if (!kind_ok(m_rights[ix], req_kind)) begin e_fault = 3; tag = "R6"; end
        else begin
          e_pa = (m_start[ix] + longint'(req_disp)) & ((64'd1 << PA_W) - 1);
          tag = (m_base != 0) ? "R2" : "R3";
        end
        if ((tbl_we && int'(tbl_idx) == ix) || cfg_base_we) tag = "R10";
      end
      if (cfg_base_we) m_base = int'(cfg_base);
      if (tbl_we) begin
        m_pres[tbl_idx] = tbl_present; m_rights[tbl_idx] = tbl_rights;
        m_len[tbl_idx] = tbl_len; m_start[tbl_idx] = tbl_start;
      end
    end
    #1;
    check(tag == "R9" ? "R9" : "R1", rsp_valid, e_valid);
    if (e_valid) begin
      check(tag, rsp_fault, e_fault);
      check(e_fault != 0 ? "R8" : tag, rsp_pa, e_pa);
    end
    if (cycles > 50000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<50000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle();
    cfg_base_we = 0; tbl_we = 0; req_valid = 0;
  endtask

  task automatic wr(int ix, bit p, int r, longint len, longint st);
    tbl_we = 1; tbl_idx = ix[SEG_W-1:0]; tbl_present = p;
    tbl_rights = r[1:0]; tbl_len = len[LEN_W-1:0]; tbl_start = st[PA_W-1:0];
  endtask

  task automatic rq(int s, longint d, int k);
    req_valid = 1; req_seg = s[SEG_W-1:0]; req_disp = d[DISP_W-1:0]; req_kind = k[1:0];
  endtask

  task automatic tick();
    @(negedge clk); idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int s = 0; s < NSEG; s++) begin rq(s, 0, 0); tick(); end   // R9 all absent
    wr(0, 1, 0, 16'h0100, 24'h010000); tick();
    wr(1, 1, 1, 16'h00FF, 24'h020000); tick();
    wr(2, 1, 2, 16'hFFFF, 24'hFFFFF0); tick();
    wr(3, 0, 1, 16'h0010, 24'h030000); tick();
    wr(15, 1, 3, 16'h0040, 24'h0F0000); tick();
    rq(0, 16'h0100, 0); tick();       // R5 equal length legal
    rq(0, 16'h0101, 0); tick();       // R5 overflow
    rq(0, 16'h0010, 1); tick();       // R6 write to read-only
    rq(1, 16'h0010, 1); tick();       // R3 read/write
    rq(2, 16'h0020, 2); tick();       // R3 wrap of physical address
    rq(2, 16'h0020, 0); tick();       // R6 read of execute-only
    rq(1, 16'h0000, 3); tick();       // R6 reserved kind
    rq(15, 16'h0000, 0); tick();      // R6 no-access rights
    rq(3, 16'h0100, 3); tick();       // R7 missing wins
    rq(0, 16'h0200, 2); tick();       // R7 overflow wins
    cfg_base_we = 1; cfg_base = 4'd14; tick();
    rq(2, 16'h0004, 0); tick();       // R2 (2+14)%16 = 0
    rq(3, 16'h0004, 1); tick();       // R2 index 1
    cfg_base_we = 1; cfg_base = 0; tick();
    rq(0, 16'h0004, 0); wr(0, 0, 0, 0, 0); tick();   // R10 old contents used
    rq(0, 16'h0004, 0); tick();       // now missing
    rq(1, 16'h0004, 0); cfg_base_we = 1; cfg_base = 4'd1; tick(); // R10 old base
    for (int n = 0; n < 3000; n++) begin
      int c;
      c = $urandom_range(0, 9);
      if (c < 3) wr($urandom_range(0, NSEG-1), $urandom_range(0, 3) != 0,
                    $urandom_range(0, 3), $urandom_range(0, 16'h0200), $urandom);
      if (c == 3) begin cfg_base_we = 1; cfg_base = SEG_W'($urandom); end
      if (c > 2) rq($urandom_range(0, NSEG-1), $urandom_range(0, 16'h0220),
                    $urandom_range(0, 3));
      tick();
    end
    repeat (3) tick();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule